// File: doc/BRIEF.md
# Wavelet Coefficient Feature Extractor

This block sits behind a wavelet smoothing filter in a heartbeat detection path. It takes one signed coefficient per sample strobe, at about 300 samples per second, and works out three features side by side. The first is a flag that marks zero crossings. The second is a two-bit code that marks local maxima and local minima of the coefficient stream. The third is a pair of adaptive amplitude thresholds, one positive and one negative. A downstream decision stage combines these features to pick out QRS complexes.

To find peaks, the block forms the first difference of the coefficients and runs the zero-crossing test on that difference. Each peak then has a magnitude. That magnitude is compared with the current threshold of the peak's own polarity. The comparison decides which running level the peak feeds: the signal-peak level or the noise-peak level. The positive side and the negative side each keep their own pair of levels, and each threshold is derived from its pair using shifts only. Every register advances on the sample strobe and on no other cycle.

Top module: `wavelet_feature_extractor`

## Requirements
- R1: After a synchronous active-low reset, the zero flag reads 0 and the peak code reads 00. Both signal levels start at the parameter SIG_INIT and both noise levels start at 0, so the positive threshold reads SIG_INIT>>2 and the negative threshold reads -(SIG_INIT>>2).
- R2: State and outputs change only on clock edges where the sample strobe is high. Between strobes the outputs hold, whatever value the coefficient input carries.
- R3: The zero flag is set for a sample whose value is exactly zero. The previous sample reads as zero straight after reset.
- R4: The zero flag is also set when the previous sample is strictly positive and the current one strictly negative, or the other way round. The flag goes up on the later of the two samples. A step from zero to a nonzero value does not count as a crossing.
- R5: Let d[n] = x[n] - x[n-1]. The peak code is 01 (maximum) when d[n-1] > 0 and d[n] <= 0. It is 10 (minimum) when d[n-1] < 0 and d[n] >= 0. It is 00 otherwise, and 11 never appears. No peak is reported until the block has taken at least two samples since reset.
- R6: The amplitude of a peak is x[n-1]. The magnitude of a maximum is x[n-1], and the magnitude of a minimum is -x[n-1]. Both are clamped to the range 0 to 8191.
- R7: A peak counts as signal when its magnitude is greater than or equal to the current threshold magnitude of its polarity. Otherwise it counts as noise. Only the matching level of that polarity moves.
- R8: A level L is updated to L + ((m - L) >>> 3), where m is the peak magnitude and >>> is an arithmetic shift that rounds toward minus infinity.
- R9: Each threshold magnitude equals N + ((S - N) >>> 2), clamped to 0 to 8191, where N is the noise level and S the signal level of that polarity. The positive output carries the magnitude and the negative output carries its negation, both as 14-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe that marks a valid coefficient |
| coef_in | input | 14 | Signed wavelet coefficient |
| xing_flag | output | 1 | Zero-crossing flag for the last strobed sample |
| peak_code | output | 2 | 01 maximum, 10 minimum, 00 none |
| thr_pos | output | 14 | Positive adaptive threshold, signed |
| thr_neg | output | 14 | Negative adaptive threshold, signed |

## Verification
The assertions assume that the strobe lasts no more than one cycle per sample. They also assume that the coefficient input is meaningful only while the strobe is high, and that reset is held for at least one strobe-free edge. The stimulus keeps to these assumptions. Each sample is strobed for exactly one cycle, followed by several idle cycles in which the coefficient input carries unrelated values. Those values test the hold rule without breaking the sampling contract. The waveform is built from growing bipolar pulses, small noise wiggles, flat plateaus, exact zeros and full-scale extremes. Together these drive both polarities through both the signal path and the noise path, and reach the clamping limits.

// File: rtl/wfx_pkg.sv
// Shared types and helpers for the wavelet feature extractor.
// Assumes callers pass sign-extended values that fit in 32 bits.
package wfx_pkg;

    typedef enum logic [1:0] {
        PK_NONE = 2'b00,
        PK_MAX  = 2'b01,
        PK_MIN  = 2'b10
    } peak_e;

    // True when the two values are strictly of opposite sign.
    function automatic logic opp_sign(input int a, input int b);
        return ((a > 0) && (b < 0)) || ((a < 0) && (b > 0));
    endfunction

endpackage

// File: rtl/wfx_zero_cross.sv
// Zero-crossing detector on the raw coefficient stream.
// Flags an exact zero, or a strict sign change relative to the previous
// strobed sample. Assumes stb is high for one cycle per sample.
module wfx_zero_cross #(
    parameter int W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic signed [W-1:0] x,
    output logic                flag
);
    import wfx_pkg::*;

    logic signed [W-1:0] x_prev;

    // Keep the previous sample and register the crossing decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev <= '0;
            flag   <= 1'b0;
        end else if (stb) begin
            x_prev <= x;
            flag   <= (x == '0) || opp_sign(int'(x_prev), int'(x));
        end
    end

    // R3: an exact zero sample raises the flag on the next cycle.
    a_r3_zero_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && x == '0) |=> flag);

endmodule

// File: rtl/wfx_peak_find.sv
// Peak finder: takes the first difference of the stream and runs the
// crossing test on it. A peak found at sample n refers to sample n-1,
// whose value is handed out as the amplitude. Needs two samples of history.
module wfx_peak_find #(
    parameter int W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic signed [W-1:0] x,
    output logic                hit_max,
    output logic                hit_min,
    output logic signed [W-1:0] amp,
    output wfx_pkg::peak_e      code
);
    import wfx_pkg::*;

    localparam int DW = W + 1;

    logic signed [W-1:0]  x_prev;
    logic signed [DW-1:0] d_prev;
    logic signed [DW-1:0] d_now;
    logic [1:0]           fill;
    logic                 hist_ok;

    // Current derivative and history qualifier.
    always_comb begin
        d_now   = DW'(x) - DW'(x_prev);
        hist_ok = (fill == 2'd2);
    end

    // Classify the extremum at n-1 from the derivative sign change.
    always_comb begin
        hit_max = stb && hist_ok && (d_prev > 0) && (d_now <= 0);
        hit_min = stb && hist_ok && (d_prev < 0) && (d_now >= 0);
        amp     = x_prev;
    end

    // Shift the history and register the peak code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev <= '0;
            d_prev <= '0;
            fill   <= 2'd0;
            code   <= PK_NONE;
        end else if (stb) begin
            x_prev <= x;
            d_prev <= d_now;
            fill   <= hist_ok ? fill : fill + 2'd1;
            code   <= hit_max ? PK_MAX : (hit_min ? PK_MIN : PK_NONE);
        end
    end

    // R5: a maximum cannot be followed directly by another maximum.
    a_r5_no_repeat_max: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && code == PK_MAX) |-> !hit_max);

    // R5: no peak before two samples of history exist.
    a_r5_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && fill != 2'd2) |=> (code == PK_NONE));

endmodule

// File: rtl/wfx_level_track.sv
// Adaptive level tracker for one polarity. Holds a signal-peak level and a
// noise-peak level, both non-negative magnitudes. Each peak is classified
// against the current threshold and moves one level by a shifted step.
module wfx_level_track #(
    parameter int W        = 14,
    parameter int SIG_INIT = 1024,
    parameter int AVG_SH   = 3,
    parameter int THR_SH   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         hit,
    input  logic [W-2:0] mag,
    output logic [W-2:0] thr_mag
);
    localparam int MAXV = 2**(W-1) - 1;
    localparam int EW   = W + 1;

    logic [W-2:0]         lvl_sig;
    logic [W-2:0]         lvl_noise;
    logic signed [EW-1:0] sig_e, noise_e, mag_e, thr_e;
    logic signed [EW-1:0] sig_nx, noise_nx;
    logic                 is_sig;

    // Widen the levels and magnitude into signed arithmetic.
    always_comb begin
        sig_e   = EW'({2'b00, lvl_sig});
        noise_e = EW'({2'b00, lvl_noise});
        mag_e   = EW'({2'b00, mag});
    end

    // Threshold between noise and signal level, clamped to range.
    always_comb begin
        thr_e = noise_e + ((sig_e - noise_e) >>> THR_SH);
        if (thr_e < 0)
            thr_mag = '0;
        else if (thr_e > MAXV)
            thr_mag = (W-1)'(MAXV);
        else
            thr_mag = thr_e[W-2:0];
    end

    // Classification and candidate next levels.
    always_comb begin
        is_sig   = (mag >= thr_mag);
        sig_nx   = sig_e + ((mag_e - sig_e) >>> AVG_SH);
        noise_nx = noise_e + ((mag_e - noise_e) >>> AVG_SH);
    end

    // Update the matching level on a strobed peak.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_sig   <= (W-1)'(SIG_INIT);
            lvl_noise <= '0;
        end else if (stb && hit) begin
            if (is_sig)
                lvl_sig   <= sig_nx[W-2:0];
            else
                lvl_noise <= noise_nx[W-2:0];
        end
    end

    // R7: a noise peak leaves the signal level alone.
    a_r7_noise_keeps_sig: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && hit && !is_sig) |=> $stable(lvl_sig));

    // R7: a signal peak leaves the noise level alone.
    a_r7_sig_keeps_noise: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && hit && is_sig) |=> $stable(lvl_noise));

    // R8: a larger signal peak never pulls the signal level down.
    a_r8_moves_toward: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && hit && is_sig && (mag >= lvl_sig)) |=> (lvl_sig >= $past(lvl_sig)));

endmodule

// File: rtl/wavelet_feature_extractor.sv
// Top of the feature extractor: zero-crossing flag, peak code and two
// adaptive thresholds from one signed coefficient stream. Assumes one
// single-cycle strobe per sample; all state advances only on that strobe.
module wavelet_feature_extractor #(
    parameter int W        = 14,
    parameter int SIG_INIT = 1024,
    parameter int AVG_SH   = 3,
    parameter int THR_SH   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_stb,
    input  logic [W-1:0] coef_in,
    output logic         xing_flag,
    output logic [1:0]   peak_code,
    output logic [W-1:0] thr_pos,
    output logic [W-1:0] thr_neg
);
    import wfx_pkg::*;

    localparam int MAXV = 2**(W-1) - 1;
    localparam int EW   = W + 1;

    logic signed [W-1:0]  x_s;
    logic                 hit_max, hit_min;
    logic signed [W-1:0]  amp;
    peak_e                code;
    logic signed [EW-1:0] amp_e, amp_neg_e;
    logic [W-2:0]         mag_pol [2];
    logic                 hit_pol [2];
    logic [W-2:0]         thr_pol [2];

    assign x_s = $signed(coef_in);

    wfx_zero_cross #(.W(W)) u_zc (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (smp_stb),
        .x    (x_s),
        .flag (xing_flag)
    );

    wfx_peak_find #(.W(W)) u_pk (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (smp_stb),
        .x      (x_s),
        .hit_max(hit_max),
        .hit_min(hit_min),
        .amp    (amp),
        .code   (code)
    );

    // Peak magnitudes per polarity, clamped to the non-negative range.
    always_comb begin
        amp_e     = EW'(amp);
        amp_neg_e = -amp_e;
        if (amp_e < 0)
            mag_pol[0] = '0;
        else
            mag_pol[0] = amp_e[W-2:0];
        if (amp_neg_e < 0)
            mag_pol[1] = '0;
        else if (amp_neg_e > MAXV)
            mag_pol[1] = (W-1)'(MAXV);
        else
            mag_pol[1] = amp_neg_e[W-2:0];
        hit_pol[0] = hit_max;
        hit_pol[1] = hit_min;
    end

    for (genvar p = 0; p < 2; p++) begin : g_pol
        wfx_level_track #(
            .W       (W),
            .SIG_INIT(SIG_INIT),
            .AVG_SH  (AVG_SH),
            .THR_SH  (THR_SH)
        ) u_lvl (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (smp_stb),
            .hit    (hit_pol[p]),
            .mag    (mag_pol[p]),
            .thr_mag(thr_pol[p])
        );
    end

    // Drive the signed threshold outputs.
    always_comb begin
        peak_code = code;
        thr_pos   = {1'b0, thr_pol[0]};
        thr_neg   = W'(-EW'({2'b00, thr_pol[1]}));
    end

    // R2: without a strobe every output holds its value.
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(xing_flag) && $stable(peak_code)
                      && $stable(thr_pos) && $stable(thr_neg)));

    // R9: the negative threshold never exceeds zero.
    a_r9_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !($signed(thr_neg) > 0));

endmodule

// File: tb/tb_wavelet_feature_extractor.sv
`timescale 1ns/1ps
module tb_wavelet_feature_extractor;

    localparam int W        = 14;
    localparam int SIG_INIT = 1024;
    localparam int GAP      = 3;
    localparam int MAXV     = 8191;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_stb = 1'b0;
    logic [W-1:0]        coef_in = '0;
    logic                xing_flag;
    logic [1:0]          peak_code;
    logic signed [W-1:0] thr_pos, thr_neg;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    typedef struct {
        logic       zc;
        logic [1:0] pk;
        int         tp;
        int         tn;
    } exp_t;
    exp_t sb_q[$];
    event chk_ev;

    // Reference state
    int m_x1 = 0, m_x2 = 0, m_fill = 0;
    int m_sig[2], m_noise[2];

    always #2 clk = ~clk;

    wavelet_feature_extractor #(.W(W), .SIG_INIT(SIG_INIT)) dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .coef_in(coef_in),
        .xing_flag(xing_flag), .peak_code(peak_code),
        .thr_pos(thr_pos), .thr_neg(thr_neg)
    );

    function automatic int clampv(int v);
        if (v < 0) return 0;
        if (v > MAXV) return MAXV;
        return v;
    endfunction

    function automatic int thr_of(int p);
        return clampv(m_noise[p] + ((m_sig[p] - m_noise[p]) >>> 2));
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Driver: model one sample, push the expectation, strobe, then idle.
    task automatic drive_sample(int x);
        exp_t e;
        int d, dp, amp, mag;
        int pol;
        e.zc = (x == 0) || (m_x1 > 0 && x < 0) || (m_x1 < 0 && x > 0);
        d  = x - m_x1;
        dp = m_x1 - m_x2;
        e.pk = 2'b00;
        pol = -1;
        if (m_fill >= 2 && dp > 0 && d <= 0) begin e.pk = 2'b01; pol = 0; end
        else if (m_fill >= 2 && dp < 0 && d >= 0) begin e.pk = 2'b10; pol = 1; end
        if (pol >= 0) begin
            amp = m_x1;
            mag = clampv(pol == 0 ? amp : -amp);
            if (mag >= thr_of(pol))
                m_sig[pol] = m_sig[pol] + ((mag - m_sig[pol]) >>> 3);
            else
                m_noise[pol] = m_noise[pol] + ((mag - m_noise[pol]) >>> 3);
        end
        m_x2 = m_x1;
        m_x1 = x;
        if (m_fill < 2) m_fill++;
        e.tp = thr_of(0);
        e.tn = -thr_of(1);
        sb_q.push_back(e);

        @(negedge clk);
        smp_stb = 1'b1;
        coef_in = W'(x);
        @(negedge clk);
        smp_stb = 1'b0;
        for (int g = 0; g < GAP; g++) begin
            coef_in = W'((x * 37 + g * 911) ^ 14'h2A5);
            @(negedge clk);
        end
        -> chk_ev;
        #0;
    endtask

    // Monitor: pop the oldest expectation and compare after the idle gap (R2 hold).
    initial begin
        forever begin
            @(chk_ev);
            if (sb_q.size() == 0) begin
                check("R2", "scoreboard underflow", 0, 1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check("R2 R3 R4", "zero flag", int'(xing_flag), int'(e.zc));
                check("R2 R5", "peak code", int'(peak_code), int'(e.pk));
                check("R6 R7 R8 R9", "positive threshold", int'(thr_pos), e.tp);
                check("R6 R7 R8 R9", "negative threshold", int'(thr_neg), e.tn);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        check("WATCHDOG", "run completed", 0, 1);
        finish_run();
    end

    // Stimulus
    initial begin
        m_sig[0] = SIG_INIT; m_sig[1] = SIG_INIT;
        m_noise[0] = 0;      m_noise[1] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "zero flag after reset", int'(xing_flag), 0);
        check("R1", "peak code after reset", int'(peak_code), 0);
        check("R1", "positive threshold after reset", int'(thr_pos), SIG_INIT >> 2);
        check("R1", "negative threshold after reset", int'(thr_neg), -(SIG_INIT >> 2));

        // R3: exact zero as the first sample; R4: zero-to-nonzero is no crossing
        drive_sample(0);
        drive_sample(25);
        drive_sample(-30);
        // Growing bipolar beats with noise and plateaus (R5, R6, R7, R8, R9)
        for (int b = 0; b < 8; b++) begin
            int a;
            a = 1500 + b * 700;
            drive_sample(20);  drive_sample(-15); drive_sample(30);
            drive_sample(10);  drive_sample(-25);
            drive_sample(a / 4);      drive_sample(a * 3 / 4);
            drive_sample(a);          drive_sample(a / 2);
            drive_sample(0);          drive_sample(-a / 2);
            drive_sample(-a * 3 / 4); drive_sample(-a / 3);
            drive_sample(-a / 10);
            drive_sample(40); drive_sample(40); drive_sample(40); drive_sample(5);
        end
        // Full-scale extremes: clamping of magnitudes (R6) and thresholds (R9)
        drive_sample(8191);  drive_sample(-8192); drive_sample(-8192);
        drive_sample(8191);  drive_sample(0);     drive_sample(-8192);
        drive_sample(8191);  drive_sample(0);     drive_sample(0);
        drive_sample(-1);    drive_sample(1);     drive_sample(-1);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule